// File: doc/BRIEF.md
# Asynchronous Strobe-Bus Slave Interface

This block lets a 16-bit host processor with an asynchronous, strobe-based bus reach an internal resource clocked by the chip's master clock. All host controls pass through two-flop synchronisers. When a cycle starts, the block raises a read request toward the resource, or it waits for the resource to report ready before it acknowledges a write. Write data is committed when the host releases its data strobes. The acknowledge is active low and can be switched off. It stays asserted until the host has let go of every strobe.

Two access paths are decoded by a region select. On the memory path each byte lane is qualified by its own strobe. On the register path the whole 16-bit word is always used. Two register-path addresses are served locally and never reach the resource. Address 0 holds the interrupt status: it collects interrupt source pulses and clears when read. Address 1 holds the interrupt mask. These two registers drive an open-drain interrupt request.

Top module: `hostbus_slave`

## Requirements
- R1: After reset, the acknowledge and data drivers are off (`hb_dtack_oe`=0, `hb_data_oe`=0), `hb_dtack_n` is 1, `hb_irq_drive` is 0 and no request is issued.
- R2: `hb_dtack_oe` is 1 only while chip select is asserted. With chip select asserted and no completed access, `hb_dtack_n` is 1. A few cycles after chip select is released, `hb_dtack_oe` returns to 0.
- R3: `hb_dtack_n` falls only after the resource has presented `rsp_ready` (or a local register is addressed). A write whose ready is held off is not acknowledged until ready arrives.
- R4: Once asserted, `hb_dtack_n` stays 0 while the address strobe or either data strobe is still asserted. After all three are released it returns to 1.
- R5: A memory-path write (`hb_regsel`=0) issues one `req_valid` pulse with `req_write`=1 on each strobe release. `req_be[1]` is set for the upper byte D[15:8] and `req_be[0]` for the lower byte D[7:0], each only when its own strobe was released. Lanes whose strobe was not asserted keep their old contents.
- R6: A register-path write (`hb_regsel`=1) to an address other than 0 or 1 commits the full 16-bit word once, with `req_be`=2'b11, after all data strobes are released. This holds whichever strobes were used.
- R7: A read issues exactly one single-cycle `req_valid` with `req_write`=0, and then returns `rsp_rdata` on `hb_data_out`. `hb_data_oe` is 1 only while the access is acknowledged with chip select, address strobe, read (`hb_rw`=1) and a data strobe all asserted. It drops after the strobes are released.
- R8: Register-path address 0 is the interrupt status. Bit i is set by a pulse on `irq_src[i]`, a read returns the pending bits, and the read clears them.
- R9: Register-path address 1 is the interrupt mask, where a 1 masks the source. It resets to all ones, reads back and is writable. `hb_irq_drive` is 1 exactly when some status bit is set while its mask bit is 0.
- R10: Accesses to register-path addresses 0 and 1 never produce `req_valid`.
- R11: Writes to the interrupt status address have no effect on its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low reset, held for at least two clocks |
| hb_cs_n | input | 1 | Host chip select, active low |
| hb_as_n | input | 1 | Host address strobe, active low |
| hb_uds_n | input | 1 | Upper byte data strobe, active low |
| hb_lds_n | input | 1 | Lower byte data strobe, active low |
| hb_rw | input | 1 | 1 = host read, 0 = host write |
| hb_regsel | input | 1 | 1 = register path, 0 = memory path |
| hb_addr | input | AW | Host word address |
| hb_data_in | input | 16 | Host write data |
| hb_data_out | output | 16 | Read data toward host |
| hb_data_oe | output | 1 | Drive enable for hb_data_out |
| hb_dtack_n | output | 1 | Data acknowledge value, active low |
| hb_dtack_oe | output | 1 | Drive enable for the acknowledge |
| hb_irq_drive | output | 1 | 1 = pull the open-drain interrupt line low |
| irq_src | input | NSRC | Interrupt source pulses |
| req_valid | output | 1 | One-cycle request to the resource |
| req_write | output | 1 | Request is a write |
| req_reg | output | 1 | Request targets the register path |
| req_addr | output | AW | Request address |
| req_be | output | 2 | Byte enables, bit 1 = D[15:8] |
| req_wdata | output | 16 | Write data |
| rsp_ready | input | 1 | Resource ready for the current access |
| rsp_rdata | input | 16 | Read data from the resource |

## Verification
The bench writes one byte lane, then the other, to the same memory word and reads it back. A design that committed both lanes on every strobe release would destroy the byte it was not given. Register-path writes are sent with a single strobe and read back as a full word, which catches a design that wrongly qualified register lanes. The bench releases the data strobes while the address strobe is still held, to show that an early release of the acknowledge would be seen as a broken handshake. It also holds write ready off for twenty cycles to expose an acknowledge that ignores the resource. Interrupt tests pulse a masked source, unmask it, then read status twice: a design lacking clear-on-read would keep the line low and return stale bits, and one that let status be written would lose a pending event.

// File: rtl/hostbus_slave.sv
module hostbus_slave #(
  parameter int AW   = 8,
  parameter int NSRC = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hb_cs_n,
  input  logic            hb_as_n,
  input  logic            hb_uds_n,
  input  logic            hb_lds_n,
  input  logic            hb_rw,
  input  logic            hb_regsel,
  input  logic [AW-1:0]   hb_addr,
  input  logic [15:0]     hb_data_in,
  output logic [15:0]     hb_data_out,
  output logic            hb_data_oe,
  output logic            hb_dtack_n,
  output logic            hb_dtack_oe,
  output logic            hb_irq_drive,
  input  logic [NSRC-1:0] irq_src,
  output logic            req_valid,
  output logic            req_write,
  output logic            req_reg,
  output logic [AW-1:0]   req_addr,
  output logic [1:0]      req_be,
  output logic [15:0]     req_wdata,
  input  logic            rsp_ready,
  input  logic [15:0]     rsp_rdata
);
  localparam logic [AW-1:0] STAT_A = '0;
  localparam logic [AW-1:0] MASK_A = AW'(1);

  typedef enum logic [1:0] {IDLE, WAIT, ACK} st_t;

  logic [5:0] sy1, sy2;
  wire  [5:0] raw = {hb_regsel, hb_rw, ~hb_lds_n, ~hb_uds_n, ~hb_as_n, ~hb_cs_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sy1 <= '0;
      sy2 <= '0;
    end else begin
      sy1 <= raw;
      sy2 <= sy1;
    end

  wire s_cs  = sy2[0];
  wire s_as  = sy2[1];
  wire s_uds = sy2[2];
  wire s_lds = sy2[3];
  wire s_rd  = sy2[4];
  wire s_reg = sy2[5];

  st_t            st;
  logic           p_uds, p_lds, ack, rd, rg;
  logic [AW-1:0]  adr;
  logic [15:0]    wbuf, rdat;
  logic [NSRC-1:0] status, mask;

  wire any_ds  = s_uds | s_lds;
  wire u_rel   = p_uds & ~s_uds;
  wire l_rel   = p_lds & ~s_lds;
  wire ds_done = (p_uds | p_lds) & ~any_ds;
  wire start   = s_cs & s_as & any_ds;
  wire done    = ~s_as & ~any_ds;
  wire loc_now = s_reg && (hb_addr == STAT_A || hb_addr == MASK_A);
  wire loc     = rg && (adr == STAT_A || adr == MASK_A);
  wire [15:0] loc_rdata = (adr == STAT_A) ? 16'(status) : 16'(mask);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; ack <= 1'b0; rd <= 1'b0; rg <= 1'b0; adr <= '0;
      p_uds <= 1'b0; p_lds <= 1'b0; wbuf <= '0; rdat <= '0;
      req_valid <= 1'b0; req_write <= 1'b0; req_reg <= 1'b0;
      req_addr <= '0; req_be <= '0; req_wdata <= '0;
    end else begin
      p_uds <= s_uds;
      p_lds <= s_lds;
      if (s_uds || (rg && any_ds)) wbuf[15:8] <= hb_data_in[15:8];
      if (s_lds || (rg && any_ds)) wbuf[7:0]  <= hb_data_in[7:0];
      req_valid <= 1'b0;
      case (st)
        IDLE: if (start) begin
          rd  <= s_rd;
          rg  <= s_reg;
          adr <= hb_addr;
          st  <= WAIT;
          if (s_rd && !loc_now) begin
            req_valid <= 1'b1;
            req_write <= 1'b0;
            req_reg   <= s_reg;
            req_addr  <= hb_addr;
            req_be    <= s_reg ? 2'b11 : {s_uds, s_lds};
          end
        end
        WAIT: if (!s_cs) st <= IDLE;
              else if (rsp_ready || loc) begin
                ack <= 1'b1;
                st  <= ACK;
                if (rd) rdat <= loc ? loc_rdata : rsp_rdata;
              end
        ACK: begin
          if (!rd && !loc) begin
            if (!rg && (u_rel || l_rel)) begin
              req_valid <= 1'b1;
              req_write <= 1'b1;
              req_reg   <= 1'b0;
              req_addr  <= adr;
              req_be    <= {u_rel, l_rel};
              req_wdata <= wbuf;
            end else if (rg && ds_done) begin
              req_valid <= 1'b1;
              req_write <= 1'b1;
              req_reg   <= 1'b1;
              req_addr  <= adr;
              req_be    <= 2'b11;
              req_wdata <= wbuf;
            end
          end
          if (done || !s_cs) begin
            ack <= 1'b0;
            st  <= IDLE;
          end
        end
        default: st <= IDLE;
      endcase
    end

  wire stat_rd  = (st == WAIT) && rd && loc && (adr == STAT_A) && s_cs;
  wire mask_wr  = (st == ACK) && !rd && loc && (adr == MASK_A) && ds_done;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
    end else begin
      status <= (stat_rd ? '0 : status) | irq_src;
      if (mask_wr) mask <= wbuf[NSRC-1:0];
    end

  assign hb_dtack_oe  = s_cs;
  assign hb_dtack_n   = ~ack;
  assign hb_data_out  = rdat;
  assign hb_data_oe   = ack & rd & s_cs & s_as & any_ds;
  assign hb_irq_drive = |(status & ~mask);
endmodule

// File: rtl/hostbus_slave_chk.sv
module hostbus_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       s_cs,
  input logic       s_as,
  input logic       s_uds,
  input logic       s_lds,
  input logic       loc,
  input logic       rsp_ready,
  input logic       hb_dtack_n,
  input logic       hb_data_oe,
  input logic       req_valid,
  input logic       req_write,
  input logic       req_reg,
  input logic [1:0] req_be
);
  a_r3_ack_after_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hb_dtack_n) |-> $past(rsp_ready || loc));

  a_r4_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!hb_dtack_n && s_cs && (s_as || s_uds || s_lds)) |=> !hb_dtack_n);

  a_r7_data_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    hb_data_oe |-> !hb_dtack_n);

  a_r7_single_read_req: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !req_valid);

  a_r5_write_has_lane: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write) |-> (req_be != 2'b00));

  a_r6_reg_full_word: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_reg) |-> (req_be == 2'b11));
endmodule

bind hostbus_slave hostbus_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .s_cs(s_cs), .s_as(s_as), .s_uds(s_uds),
  .s_lds(s_lds), .loc(loc), .rsp_ready(rsp_ready), .hb_dtack_n(hb_dtack_n),
  .hb_data_oe(hb_data_oe), .req_valid(req_valid), .req_write(req_write),
  .req_reg(req_reg), .req_be(req_be)
);

// File: tb/hostbus_slave_bench.sv
module hostbus_slave_bench;
  localparam int AW = 8;
  localparam int NSRC = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, as_n = 1'b1, uds_n = 1'b1, lds_n = 1'b1, rw = 1'b1, regsel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] din = '0;
  logic [15:0] dout;
  logic data_oe, dtack_n, dtack_oe, irq_drive;
  logic [NSRC-1:0] irq_src = '0;
  logic req_valid, req_write, req_reg;
  logic [AW-1:0] req_addr;
  logic [1:0] req_be;
  logic [15:0] req_wdata;
  logic rsp_ready;
  logic [15:0] rsp_rdata;

  int checks = 0, errors = 0, cycles = 0, nreq = 0;
  logic cur_w = 1'b0, rdy_w = 1'b1, rd_rdy = 1'b0;
  int lat_cnt = 0;
  logic [15:0] mem [16];
  logic [15:0] expm [16];
  logic [15:0] rdq = '0;

  always #2 clk = ~clk;

  hostbus_slave #(.AW(AW), .NSRC(NSRC)) u_hostbus_slave (
    .clk(clk), .rst_n(rst_n), .hb_cs_n(cs_n), .hb_as_n(as_n), .hb_uds_n(uds_n),
    .hb_lds_n(lds_n), .hb_rw(rw), .hb_regsel(regsel), .hb_addr(addr),
    .hb_data_in(din), .hb_data_out(dout), .hb_data_oe(data_oe),
    .hb_dtack_n(dtack_n), .hb_dtack_oe(dtack_oe), .hb_irq_drive(irq_drive),
    .irq_src(irq_src), .req_valid(req_valid), .req_write(req_write),
    .req_reg(req_reg), .req_addr(req_addr), .req_be(req_be),
    .req_wdata(req_wdata), .rsp_ready(rsp_ready), .rsp_rdata(rsp_rdata)
  );

  assign rsp_ready = cur_w ? rdy_w : rd_rdy;
  assign rsp_rdata = rdq;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cs_n) rd_rdy <= 1'b0;
    if (req_valid) begin
      nreq <= nreq + 1;
      if (req_write) begin
        if (req_be[1]) mem[{req_reg, req_addr[2:0]}][15:8] = req_wdata[15:8];
        if (req_be[0]) mem[{req_reg, req_addr[2:0]}][7:0]  = req_wdata[7:0];
      end else begin
        rd_rdy <= 1'b0;
        rdq <= mem[{req_reg, req_addr[2:0]}];
        lat_cnt <= 3;
      end
    end else if (lat_cnt > 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) rd_rdy <= 1'b1;
    end
  end

  task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    wait (cycles > 100000);
    chk(1'b0, "watchdog", cycles, 100000);
    finish_run();
  end

  // one host bus cycle; reports read data, wait cycles and handshake observations
  task automatic access(input logic w, input logic rs, input logic [AW-1:0] a,
                        input logic [15:0] d, input logic u, input logic l,
                        output logic [15:0] rdata, output int waited,
                        output logic oe_rd, output logic held, output logic oe_after,
                        output logic rel_ok, output logic cs_ok);
    @(negedge clk);
    cur_w = w; cs_n = 1'b0; as_n = 1'b0; rw = ~w; regsel = rs; addr = a; din = d;
    @(negedge clk);
    uds_n = ~u; lds_n = ~l;
    waited = 0;
    while (!(dtack_oe && !dtack_n) && waited < 80) begin
      @(negedge clk);
      waited++;
    end
    rdata = dout;
    oe_rd = data_oe;
    uds_n = 1'b1; lds_n = 1'b1;
    repeat (5) @(negedge clk);
    held = !dtack_n;
    oe_after = data_oe;
    as_n = 1'b1;
    repeat (5) @(negedge clk);
    rel_ok = dtack_n;
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    cs_ok = !dtack_oe;
    cur_w = 1'b0;
  endtask

  // {write, regpath, addr[7:0], data[15:0], upper, lower}
  localparam logic [27:0] VEC [10] = '{
    {1'b1, 1'b0, 8'h02, 16'h1234, 1'b1, 1'b1},
    {1'b0, 1'b0, 8'h02, 16'h0000, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'h03, 16'hABCD, 1'b1, 1'b0},
    {1'b0, 1'b0, 8'h03, 16'h0000, 1'b1, 1'b1},
    {1'b1, 1'b0, 8'h03, 16'hEF99, 1'b0, 1'b1},
    {1'b0, 1'b0, 8'h03, 16'h0000, 1'b1, 1'b1},
    {1'b1, 1'b1, 8'h05, 16'h5A5A, 1'b1, 1'b0},
    {1'b0, 1'b1, 8'h05, 16'h0000, 1'b1, 1'b1},
    {1'b1, 1'b1, 8'h06, 16'hC3C3, 1'b0, 1'b1},
    {1'b0, 1'b1, 8'h06, 16'h0000, 1'b0, 1'b1}
  };

  initial begin
    logic [15:0] rdata;
    int waited, n0;
    logic oe_rd, held, oe_after, rel_ok, cs_ok;
    for (int i = 0; i < 16; i++) begin
      mem[i]  = 16'h8000 + 16'(i) * 16'h0101;
      expm[i] = 16'h8000 + 16'(i) * 16'h0101;
    end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!dtack_oe, "R1 dtack_oe", dtack_oe, 0);
    chk(dtack_n, "R1 dtack_n", dtack_n, 1);
    chk(!data_oe, "R1 data_oe", data_oe, 0);
    chk(!irq_drive, "R1 irq_drive", irq_drive, 0);
    chk(nreq == 0, "R1 no request", nreq, 0);

    // R2 chip select alone enables acknowledge driver, value released
    cs_n = 1'b0;
    repeat (5) @(negedge clk);
    chk(dtack_oe, "R2 dtack_oe with cs", dtack_oe, 1);
    chk(dtack_n, "R2 dtack_n idle", dtack_n, 1);
    cs_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(!dtack_oe, "R2 dtack_oe after cs", dtack_oe, 0);

    // vector table
    for (int v = 0; v < 10; v++) begin
      logic w, rs, u, l;
      logic [7:0] a;
      logic [15:0] d;
      int idx;
      {w, rs, a, d, u, l} = VEC[v];
      idx = {rs, a[2:0]};
      n0 = nreq;
      access(w, rs, a, d, u, l, rdata, waited, oe_rd, held, oe_after, rel_ok, cs_ok);
      chk(waited < 80, "R3 ack arrives", waited, 80);
      chk(held, "R4 ack held while as low", held, 1);
      chk(rel_ok, "R4 ack released", rel_ok, 1);
      chk(cs_ok, "R2 driver off after cs", cs_ok, 1);
      chk(nreq == n0 + 1, w ? (rs ? "R6 one write request" : "R5 one write request") : "R7 one read request", nreq - n0, 1);
      if (w) begin
        if (rs) expm[idx] = d;
        else begin
          if (u) expm[idx][15:8] = d[15:8];
          if (l) expm[idx][7:0]  = d[7:0];
        end
      end else begin
        chk(rdata == expm[idx], rs ? "R6 register word readback" : "R5 lane readback", rdata, expm[idx]);
        chk(oe_rd, "R7 data driven", oe_rd, 1);
        chk(!oe_after, "R7 data released after strobes", oe_after, 0);
      end
    end

    // R3 delayed write ready
    rdy_w = 1'b0;
    fork
      begin
        repeat (22) @(negedge clk);
        rdy_w = 1'b1;
      end
    join_none
    access(1'b1, 1'b0, 8'h04, 16'h7777, 1'b1, 1'b1, rdata, waited, oe_rd, held, oe_after, rel_ok, cs_ok);
    chk(waited >= 18 && waited < 80, "R3 ack waits for ready", waited, 20);

    // interrupts
    n0 = nreq;
    @(negedge clk); irq_src = 8'h01;
    @(negedge clk); irq_src = 8'h00;
    repeat (2) @(negedge clk);
    chk(!irq_drive, "R9 masked after reset", irq_drive, 0);
    access(1'b0, 1'b1, 8'h01, 16'h0, 1'b1, 1'b1, rdata, waited, oe_rd, held, oe_after, rel_ok, cs_ok);
    chk(rdata == 16'h00FF, "R9 mask reset value", rdata, 16'h00FF);
    access(1'b0, 1'b1, 8'h00, 16'h0, 1'b1, 1'b1, rdata, waited, oe_rd, held, oe_after, rel_ok, cs_ok);
    chk(rdata == 16'h0001, "R8 status pending", rdata, 16'h0001);
    access(1'b0, 1'b1, 8'h00, 16'h0, 1'b1, 1'b1, rdata, waited, oe_rd, held, oe_after, rel_ok, cs_ok);
    chk(rdata == 16'h0000, "R8 cleared by read", rdata, 16'h0000);
    @(negedge clk); irq_src = 8'h04;
    @(negedge clk); irq_src = 8'h00;
    access(1'b1, 1'b1, 8'h01, 16'h00FB, 1'b1, 1'b0, rdata, waited, oe_rd, held, oe_after, rel_ok, cs_ok);
    chk(irq_drive, "R9 unmasked source drives", irq_drive, 1);
    access(1'b0, 1'b1, 8'h01, 16'h0, 1'b0, 1'b1, rdata, waited, oe_rd, held, oe_after, rel_ok, cs_ok);
    chk(rdata == 16'h00FB, "R9 mask readback", rdata, 16'h00FB);
    access(1'b1, 1'b1, 8'h00, 16'h0000, 1'b1, 1'b1, rdata, waited, oe_rd, held, oe_after, rel_ok, cs_ok);
    chk(irq_drive, "R11 status write ignored line", irq_drive, 1);
    access(1'b0, 1'b1, 8'h00, 16'h0, 1'b1, 1'b1, rdata, waited, oe_rd, held, oe_after, rel_ok, cs_ok);
    chk(rdata == 16'h0004, "R11 status survives write", rdata, 16'h0004);
    chk(!irq_drive, "R8 line released after read", irq_drive, 0);
    chk(nreq == n0, "R10 local access no request", nreq - n0, 0);
    finish_run();
  end
endmodule